// File: doc/BRIEF.md
# Intra-Line Wear-Leveling Placement Unit

This block chooses where a compressed payload lands inside one 64-byte physical memory line, so that successive writes to the same line land on different cells. The line is cut into four equal 16-byte sections. A 2-bit placement tag, stored with the line next to its 2-bit compression tag, names the section where the payload begins. On each write the unit advances that tag past the sections the previous payload used. It then rotates the new payload so that it starts at the chosen section and wraps from the last section back to the first. Finally it issues a per-byte write-enable mask, so that cells the payload does not cover are left alone.

The write path takes the new compression tag, the new payload length, and the previous placement tag and payload length read from the line. It registers the placed image, the mask and the new tag one cycle later. A separate combinational read path takes a stored line and its placement tag and rotates the payload back to logical byte 0.

Top module: `wlp_place_unit`

## Requirements
- R1: While reset is asserted and after it is released, out_valid, out_tag, out_line and out_byte_we are all zero until the first accepted write.
- R2: out_valid is high in exactly the cycle after a cycle with wr_valid high. The outputs of a request appear after the same clock edge that samples it.
- R3: A compression tag of 00 means raw data. The new tag is 0, the image equals wr_payload unrotated, and all 64 byte enables are set, whatever wr_len is.
- R4: For any compression tag other than 00, the new tag is (wr_prev_tag + ceil(wr_prev_len / 16)) mod 4. A previous length of 0 or 64 therefore leaves the tag unchanged.
- R5: For compressed data, logical payload byte i (byte i = wr_payload bits 8i+7..8i) is placed at physical byte (16*tag + i) mod 64. It wraps from byte 63 to byte 0.
- R6: For compressed data, out_byte_we bit p is set exactly when p is the placement of some logical byte i < wr_len, so a length of 0 gives an empty mask. wr_len must not exceed 64.
- R7: Every image byte whose enable bit is clear reads zero, so payload bytes beyond wr_len never reach the image.
- R8: The read path is combinational. rd_payload byte i equals rd_line byte (16*rd_tag + i) mod 64, which undoes the R5 rotation.
- R9: In a cycle without wr_valid, out_tag, out_line and out_byte_we keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write placement request |
| wr_comp | input | 2 | Compression tag of the new data (00 = raw) |
| wr_len | input | 7 | New payload length in bytes, 0 to 64 |
| wr_prev_tag | input | 2 | Placement tag currently stored with the line |
| wr_prev_len | input | 7 | Length in bytes of the payload currently stored |
| wr_payload | input | 512 | New payload, logical byte 0 in bits 7..0 |
| out_valid | output | 1 | Placed result valid |
| out_tag | output | 2 | New placement tag to store |
| out_line | output | 512 | Physical line image |
| out_byte_we | output | 64 | Per-byte write enable for out_line |
| rd_tag | input | 2 | Stored placement tag of the line being read |
| rd_line | input | 512 | Stored physical line |
| rd_payload | output | 512 | Payload rotated back to logical byte 0 |

## Verification
Raw writes are given short lengths and junk bytes, which separates the raw rule (full mask, no rotation) from the compressed rule. Compressed writes are driven from every previous tag, with previous lengths that fall on and between section boundaries, including 0 and 64. Payloads that cross byte 63 show whether the wrap is handled, and zero and full-length payloads probe the edges of the mask. Payload bytes past the length are filled with nonzero junk, so any leakage shows in the image. A chained sequence feeds each result back as the next previous tag. A round trip through the read path, for all four tags, recovers the logical payload.

// File: rtl/wlp_pkg.sv
package wlp_pkg;
   typedef logic [1:0] comp_tag_t;
   localparam comp_tag_t COMP_RAW = 2'b00;

   function automatic logic is_packed(input comp_tag_t t);
      return t != COMP_RAW;
   endfunction
endpackage

// File: rtl/wlp_next_tag.sv
module wlp_next_tag #(
   parameter int LINE_BYTES = 64,
   parameter int SECTIONS   = 4,
   localparam int TAG_W     = $clog2(SECTIONS),
   localparam int LEN_W     = $clog2(LINE_BYTES + 1),
   localparam int SEC_BYTES = LINE_BYTES / SECTIONS,
   localparam int SEC_SH    = $clog2(SEC_BYTES)
) (
   input  logic             packed_data,
   input  logic [TAG_W-1:0] prev_tag,
   input  logic [LEN_W-1:0] prev_len,
   output logic [TAG_W-1:0] next_tag
);
   logic [LEN_W:0] rounded;
   logic [LEN_W:0] sec_used;

   always_comb begin
      rounded  = {1'b0, prev_len} + (LEN_W+1)'(SEC_BYTES - 1);
      sec_used = rounded >> SEC_SH;
      if (packed_data) next_tag = prev_tag + sec_used[TAG_W-1:0];
      else             next_tag = '0;
   end
endmodule

// File: rtl/wlp_span_mask.sv
module wlp_span_mask #(
   parameter int LINE_BYTES = 64,
   localparam int LEN_W     = $clog2(LINE_BYTES + 1)
) (
   input  logic                  full,
   input  logic [LEN_W-1:0]      len,
   output logic [LINE_BYTES-1:0] en
);
   for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
      assign en[i] = full | (len > LEN_W'(i));
   end
endmodule

// File: rtl/wlp_rotator.sv
module wlp_rotator #(
   parameter int ELEMS    = 64,
   parameter int ELEM_W   = 8,
   parameter int SECTIONS = 4,
   parameter bit TO_LINE  = 1'b1,
   localparam int TAG_W   = $clog2(SECTIONS),
   localparam int STEP    = ELEMS / SECTIONS,
   localparam int W       = ELEMS * ELEM_W
) (
   input  logic [W-1:0]     din,
   input  logic [TAG_W-1:0] sel,
   output logic [W-1:0]     dout
);
   logic [W-1:0] cand [SECTIONS];

   for (genvar s = 0; s < SECTIONS; s++) begin : g_shift
      for (genvar j = 0; j < ELEMS; j++) begin : g_elem
         if (TO_LINE) begin : g_fwd
            assign cand[s][j*ELEM_W +: ELEM_W] =
               din[((j + ELEMS - s*STEP) % ELEMS)*ELEM_W +: ELEM_W];
         end else begin : g_back
            assign cand[s][j*ELEM_W +: ELEM_W] =
               din[((j + s*STEP) % ELEMS)*ELEM_W +: ELEM_W];
         end
      end
   end

   assign dout = cand[sel];
endmodule

// File: rtl/wlp_place_unit.sv
module wlp_place_unit
   import wlp_pkg::*;
#(
   parameter int LINE_BYTES = 64,
   parameter int SECTIONS   = 4,
   localparam int TAG_W     = $clog2(SECTIONS),
   localparam int LEN_W     = $clog2(LINE_BYTES + 1),
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int SEC_BYTES = LINE_BYTES / SECTIONS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_valid,
   input  logic [1:0]            wr_comp,
   input  logic [LEN_W-1:0]      wr_len,
   input  logic [TAG_W-1:0]      wr_prev_tag,
   input  logic [LEN_W-1:0]      wr_prev_len,
   input  logic [LINE_W-1:0]     wr_payload,
   output logic                  out_valid,
   output logic [TAG_W-1:0]      out_tag,
   output logic [LINE_W-1:0]     out_line,
   output logic [LINE_BYTES-1:0] out_byte_we,
   input  logic [TAG_W-1:0]      rd_tag,
   input  logic [LINE_W-1:0]     rd_line,
   output logic [LINE_W-1:0]     rd_payload
);
   if ((SECTIONS & (SECTIONS - 1)) != 0 || SECTIONS < 2) begin : g_bad_sec
      $error("SECTIONS must be a power of two of at least 2");
   end
   if (LINE_BYTES % SECTIONS != 0) begin : g_bad_line
      $error("LINE_BYTES must divide evenly into SECTIONS");
   end

   logic                  packed_data;
   logic [TAG_W-1:0]      tag_nx;
   logic [LINE_BYTES-1:0] log_en, phys_en;
   logic [LINE_W-1:0]     log_bits, log_data, phys_data;

   assign packed_data = is_packed(comp_tag_t'(wr_comp));

   wlp_next_tag #(.LINE_BYTES(LINE_BYTES), .SECTIONS(SECTIONS)) u_tag (
      .packed_data(packed_data), .prev_tag(wr_prev_tag),
      .prev_len(wr_prev_len), .next_tag(tag_nx));

   wlp_span_mask #(.LINE_BYTES(LINE_BYTES)) u_span (
      .full(!packed_data), .len(wr_len), .en(log_en));

   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_expand
      assign log_bits[b*8 +: 8] = {8{log_en[b]}};
   end
   assign log_data = wr_payload & log_bits;

   wlp_rotator #(.ELEMS(LINE_BYTES), .ELEM_W(8), .SECTIONS(SECTIONS), .TO_LINE(1'b1)) u_rot_data (
      .din(log_data), .sel(tag_nx), .dout(phys_data));

   wlp_rotator #(.ELEMS(LINE_BYTES), .ELEM_W(1), .SECTIONS(SECTIONS), .TO_LINE(1'b1)) u_rot_mask (
      .din(log_en), .sel(tag_nx), .dout(phys_en));

   wlp_rotator #(.ELEMS(LINE_BYTES), .ELEM_W(8), .SECTIONS(SECTIONS), .TO_LINE(1'b0)) u_rot_read (
      .din(rd_line), .sel(rd_tag), .dout(rd_payload));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_tag     <= '0;
         out_line    <= '0;
         out_byte_we <= '0;
      end else begin
         out_valid <= wr_valid;
         if (wr_valid) begin
            out_tag     <= tag_nx;
            out_line    <= phys_data;
            out_byte_we <= phys_en;
         end
      end
   end

   // checks beside the logic they guard
   logic [LINE_W-1:0] out_we_bits;
   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_we_bits
      assign out_we_bits[b*8 +: 8] = {8{out_byte_we[b]}};
   end

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> out_valid);
   assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> !out_valid);
   assert_raw_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_comp == 2'b00) |=> (out_tag == '0 && &out_byte_we));
   assert_tag_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_comp != 2'b00) |=>
      out_tag == TAG_W'($past(wr_prev_tag) + ($past(wr_prev_len) + SEC_BYTES - 1) / SEC_BYTES));
   assert_first_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_comp != 2'b00 && wr_len != '0) |=>
      out_line[int'(out_tag)*SEC_BYTES*8 +: 8] == $past(wr_payload[7:0]));
   assert_mask_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_comp != 2'b00) |=> $countones(out_byte_we) == int'($past(wr_len)));
   assert_len_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> int'(wr_len) <= LINE_BYTES);
   assert_unwritten_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_line & ~out_we_bits) == '0);
   assert_read_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_payload[7:0] == rd_line[int'(rd_tag)*SEC_BYTES*8 +: 8]);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> ($stable(out_tag) && $stable(out_line) && $stable(out_byte_we)));
endmodule

// File: tb/sim_wlp_place_unit.sv
`timescale 1ns/1ps
module sim_wlp_place_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_valid = 1'b0;
   logic [1:0]   wr_comp = '0;
   logic [6:0]   wr_len = '0;
   logic [1:0]   wr_prev_tag = '0;
   logic [6:0]   wr_prev_len = '0;
   logic [511:0] wr_payload = '0;
   logic         out_valid;
   logic [1:0]   out_tag;
   logic [511:0] out_line;
   logic [63:0]  out_byte_we;
   logic [1:0]   rd_tag = '0;
   logic [511:0] rd_line = '0;
   logic [511:0] rd_payload;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   wlp_place_unit u0 (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [511:0] make_pay(input int seed);
      logic [511:0] p;
      for (int i = 0; i < 64; i++) p[i*8 +: 8] = 8'(i*7 + seed*13 + 1) | 8'h01;
      return p;
   endfunction

   task automatic model(input logic [511:0] pay, input int len, input logic [1:0] comp,
                        input int ptag, input int plen, output int etag,
                        output logic [63:0] ewe, output logic [511:0] eline);
      if (comp == 2'b00) begin
         etag = 0; ewe = '1; eline = pay;
      end else begin
         etag = (ptag + (plen + 15) / 16) % 4;
         ewe = '0; eline = '0;
         for (int i = 0; i < len; i++) begin
            int p;
            p = (etag*16 + i) % 64;
            ewe[p] = 1'b1;
            eline[p*8 +: 8] = pay[i*8 +: 8];
         end
      end
   endtask

   task automatic do_write(input logic [511:0] pay, input int len, input logic [1:0] comp,
                           input int ptag, input int plen, input string req);
      int etag; logic [63:0] ewe; logic [511:0] eline;
      model(pay, len, comp, ptag, plen, etag, ewe, eline);
      @(negedge clk);
      wr_valid = 1'b1; wr_payload = pay; wr_len = 7'(len); wr_comp = comp;
      wr_prev_tag = 2'(ptag); wr_prev_len = 7'(plen);
      @(negedge clk);
      wr_valid = 1'b0;
      chk(out_valid === 1'b1, "R2", "out_valid", 512'(out_valid), 512'(1));
      chk(out_tag === 2'(etag), req, "tag", 512'(out_tag), 512'(etag));
      chk(out_byte_we === ewe, req, "byte_we", 512'(out_byte_we), 512'(ewe));
      chk(out_line === eline, req, "line", out_line, eline);
   endtask

   task automatic t_reset();
      chk(out_valid === 1'b0, "R1", "valid", 512'(out_valid), 512'(0));
      chk(out_tag === 2'b00, "R1", "tag", 512'(out_tag), 512'(0));
      chk(out_byte_we === '0 && out_line === '0, "R1", "we/line",
          512'(out_byte_we), 512'(0));
   endtask

   task automatic t_raw();
      do_write(make_pay(1), 64, 2'b00, 2, 30, "R3");
      do_write(make_pay(2), 5, 2'b00, 3, 10, "R3");
   endtask

   task automatic t_compressed();
      do_write(make_pay(3), 20, 2'b01, 0, 20, "R4");
      do_write(make_pay(4), 10, 2'b10, 1, 17, "R4");
      do_write(make_pay(5), 16, 2'b11, 2, 0, "R4");
      do_write(make_pay(6), 16, 2'b01, 1, 64, "R4");
      do_write(make_pay(7), 30, 2'b01, 3, 16, "R4");
   endtask

   task automatic t_wrap();
      do_write(make_pay(8), 40, 2'b01, 2, 12, "R5");
      do_write(make_pay(9), 64, 2'b10, 1, 33, "R5");
   endtask

   task automatic t_edges();
      do_write(make_pay(10), 0, 2'b01, 0, 48, "R6");
      do_write(make_pay(11), 1, 2'b11, 3, 1, "R7");
   endtask

   task automatic t_hold();
      logic [1:0] t0; logic [63:0] w0; logic [511:0] l0;
      do_write(make_pay(12), 24, 2'b01, 1, 20, "R9");
      t0 = out_tag; w0 = out_byte_we; l0 = out_line;
      @(negedge clk);
      wr_payload = make_pay(13); wr_len = 7'd3; wr_prev_tag = 2'd0; wr_comp = 2'b00;
      repeat (3) @(negedge clk);
      chk(out_valid === 1'b0, "R2", "valid idle", 512'(out_valid), 512'(0));
      chk(out_tag === t0 && out_byte_we === w0, "R9", "tag/we hold",
          512'({out_tag, out_byte_we}), 512'({t0, w0}));
      chk(out_line === l0, "R9", "line hold", out_line, l0);
   endtask

   task automatic t_chain();
      int ptag = 0; int plen = 0;
      for (int k = 0; k < 5; k++) begin
         int len;
         len = 9 + k*11;
         do_write(make_pay(20 + k), len, 2'b01, ptag, plen, "R4");
         ptag = out_tag; plen = len;
      end
   endtask

   task automatic t_read();
      logic [511:0] pay, exp;
      pay = make_pay(30);
      for (int t = 0; t < 4; t++) begin
         exp = '0;
         for (int i = 0; i < 64; i++) exp[i*8 +: 8] = pay[((t*16 + i) % 64)*8 +: 8];
         @(negedge clk);
         rd_tag = 2'(t); rd_line = pay;
         #1;
         chk(rd_payload === exp, "R8", "read rotate", rd_payload, exp);
      end
      do_write(pay, 50, 2'b10, 3, 40, "R5");
      @(negedge clk);
      rd_tag = out_tag; rd_line = out_line;
      #1;
      exp = '0;
      for (int i = 0; i < 50; i++) exp[i*8 +: 8] = pay[i*8 +: 8];
      chk(rd_payload === exp, "R8", "round trip", rd_payload, exp);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_raw();
      t_compressed();
      t_wrap();
      t_edges();
      t_hold();
      t_chain();
      t_read();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule